// File: doc/BRIEF.md
# Byte-Wide Parallel NOR Flash Bus Cycle Engine

This block turns a one-cycle request into a single read or write bus cycle on an asynchronous parallel NOR flash that is wired for 8-bit access. The requester supplies a 24-bit byte address, a write flag and a write byte. The block puts the address on the flash pins, sequences the chip-enable, output-enable and write-enable strobes, and decides when the FPGA drives the data pins and when it releases them. For a read it captures the byte the flash returns and hands it back with a one-cycle completion pulse.

All flash timing comes from counting cycles of the system clock. The defaults are sized for a 50 MHz clock. A read holds its strobes for 5 cycles (100 ns), which covers a 75 ns access time. A write holds its strobe for 6 cycles (120 ns), which covers a 60 ns setup time for data and address. Only the low data byte is involved. Command sequences, status polling and erase handling sit in the logic that issues the requests, not in this block.

Top module: `nor_byte_cycle_engine`

## Requirements
- R1: After reset and whenever no cycle is running, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, `flash_dq_oe` is 0, and `done` and `busy` are 0.
- R2: When `req_valid` is sampled high while idle, the request is accepted at that clock edge. `flash_addr` shows `req_addr` from the next cycle and stays unchanged through the cycle in which `done` is high.
- R3: A read holds `flash_ce_n`=0, `flash_oe_n`=0 and `flash_we_n`=1 for exactly RD_ACCESS_CYC (default 5) consecutive cycles. These cycles begin one cycle after the address first appears.
- R4: For a read, `rd_data` takes the value of `flash_dq_in` at the clock edge that ends the last strobe cycle. That is the earliest point at which RD_ACCESS_CYC cycles have elapsed. `rd_data` holds that value while `done` is high and until the next read captures new data.
- R5: A write holds `flash_ce_n`=0, `flash_we_n`=0 and `flash_oe_n`=1 for exactly WR_PULSE_CYC (default 6) consecutive cycles. These cycles begin one cycle after the address first appears.
- R6: For a write, `flash_dq_oe` is 1 and `flash_dq_out` equals `req_wdata` from the cycle the address appears through the cycle after `flash_we_n` returns high. That span is WR_PULSE_CYC+2 cycles. For a read, `flash_dq_oe` stays 0.
- R7: After the strobes are released, the address (and the write data, for a write) is held for one more cycle before completion.
- R8: `done` is high for exactly one cycle, the cycle after the hold cycle. Counting from the first cycle in which the address is shown, it rises in cycle RD_ACCESS_CYC+3 for a read and WR_PULSE_CYC+3 for a write. `busy` is 1 from the cycle after acceptance up to, but not including, the `done` cycle.
- R9: A request presented while `busy` is 1 is ignored. It changes neither the address nor the strobes, produces no extra `done`, and does not write the flash.
- R10: `flash_oe_n` and `flash_we_n` are never 0 together, and `flash_dq_oe` is never 1 while `flash_oe_n` is 0.
- R11: A write cycle leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle, taken only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte |
| flash_addr | output | 24 | Flash address pins |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_dq_out | output | 8 | Byte driven onto the low data pins |
| flash_dq_oe | output | 8 | Drive enable for the low data pins (1 = FPGA drives) |
| flash_dq_in | input | 8 | Byte read from the low data pins |

## Verification
The hardest case to reach is an early capture. A design that samples one edge too soon still returns plausible data from an ideal memory. To expose it, the bench flash model returns the bitwise complement of the stored byte until output enable has been low for RD_ACCESS_CYC-1 edges, so a capture one edge early produces wrong data. A second hard case is a request that arrives partway through a cycle. Random operations include a competing request, with an inverted address and data, raised in the middle of a running cycle. The bench then checks that exactly one `done` occurs, that the address stays stable, and that a later read of the competing address shows that the flash was never written.

// File: rtl/nor_cyc_pkg.sv
package nor_cyc_pkg;
  typedef enum logic [1:0] {
    NC_IDLE   = 2'd0,
    NC_SETUP  = 2'd1,
    NC_ACTIVE = 2'd2,
    NC_HOLD   = 2'd3
  } nc_state_e;

  function automatic int nc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nor_cyc_timer.sv
module nor_cyc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_cyc_seq.sv
module nor_cyc_seq
  import nor_cyc_pkg::*;
#(
  parameter int RD_CYC = 5,
  parameter int WR_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic capture,
  output logic finish,
  output logic op_wr,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic done,
  output logic busy
);
  localparam int CNT_W = $clog2(nc_max(RD_CYC, WR_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  nc_state_e state_q;
  logic      expired;
  logic      last_beat;

  nor_cyc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (state_q == NC_SETUP),
    .load_val (op_wr ? WR_LOAD : RD_LOAD),
    .tick     (state_q == NC_ACTIVE),
    .expired  (expired)
  );

  assign accept    = (state_q == NC_IDLE) && req_valid;
  assign last_beat = (state_q == NC_ACTIVE) && expired;
  assign capture   = last_beat && !op_wr;
  assign finish    = (state_q == NC_HOLD);
  assign busy      = (state_q != NC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NC_IDLE;
      op_wr   <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        NC_IDLE: begin
          if (req_valid) begin
            op_wr   <= req_write;
            state_q <= NC_SETUP;
          end
        end
        NC_SETUP: begin
          ce_n    <= 1'b0;
          oe_n    <= op_wr;
          we_n    <= !op_wr;
          state_q <= NC_ACTIVE;
        end
        NC_ACTIVE: begin
          if (expired) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            state_q <= NC_HOLD;
          end
        end
        NC_HOLD: begin
          done    <= 1'b1;
          state_q <= NC_IDLE;
        end
        default: state_q <= NC_IDLE;
      endcase
    end
  end

  // Checker counter: length of the chip-enable low window.
  logic [CNT_W:0] low_len_q;
  always_ff @(posedge clk) begin
    if (rst)       low_len_q <= '0;
    else if (!ce_n) low_len_q <= low_len_q + 1'b1;
    else           low_len_q <= '0;
  end

  // R3
  rd_strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ce_n) && !op_wr) |-> (low_len_q == (CNT_W+1)'(RD_CYC)));
  // R5
  wr_strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ce_n) && op_wr) |-> (low_len_q == (CNT_W+1)'(WR_CYC)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ce_n && oe_n && we_n && !done));
  // R7
  hold_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_n) |-> (busy && !done));
endmodule

// File: rtl/nor_cyc_datapath.sv
module nor_cyc_datapath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              finish,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flash_addr <= '0;
      dq_out     <= '0;
      dq_oe      <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        flash_addr <= req_addr;
        dq_out     <= req_wdata;
        dq_oe      <= {DATA_W{req_write}};
      end else if (finish) begin
        dq_oe      <= '0;
      end
      if (capture) rd_data <= dq_in;
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rd_data));
endmodule

// File: rtl/nor_byte_cycle_engine.sv
module nor_byte_cycle_engine #(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 8,
  parameter int RD_ACCESS_CYC = 5,
  parameter int WR_PULSE_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic [DATA_W-1:0] flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_in
);
  logic accept, capture, finish, op_wr;

  nor_cyc_seq #(.RD_CYC(RD_ACCESS_CYC), .WR_CYC(WR_PULSE_CYC)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .capture   (capture),
    .finish    (finish),
    .op_wr     (op_wr),
    .ce_n      (flash_ce_n),
    .oe_n      (flash_oe_n),
    .we_n      (flash_we_n),
    .done      (done),
    .busy      (busy)
  );

  nor_cyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .finish     (finish),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .dq_in      (flash_dq_in),
    .flash_addr (flash_addr),
    .dq_out     (flash_dq_out),
    .dq_oe      (flash_dq_oe),
    .rd_data    (rd_data)
  );

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !((flash_dq_oe != '0) && !flash_oe_n));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!flash_oe_n && !flash_we_n));
  // R6
  drive_during_we_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> (flash_dq_oe == '1));
  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(flash_addr));
  // R9
  data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(flash_dq_out));
endmodule

// File: tb/test_nor_byte_cycle_engine.sv
module test_nor_byte_cycle_engine;
  localparam int RD = 5;
  localparam int WR = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [23:0] flash_addr;
  logic        flash_ce_n, flash_oe_n, flash_we_n;
  logic [7:0]  flash_dq_out, flash_dq_oe, flash_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nor_byte_cycle_engine i_nor_byte_cycle_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in)
  );

  // Behavioural flash: 256 bytes indexed by the low address byte.
  logic [7:0] fmem [256];
  logic [7:0] shadow [256];
  int oe_age = 0;
  always @(posedge clk) begin
    if (!flash_ce_n && !flash_oe_n) oe_age <= oe_age + 1;
    else oe_age <= 0;
    if (!flash_ce_n && !flash_we_n) fmem[flash_addr[7:0]] <= flash_dq_out;
  end
  // Data is only valid once the access time has elapsed.
  assign flash_dq_in = (oe_age >= RD - 1) ? fmem[flash_addr[7:0]] : ~fmem[flash_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] last_rd = 8'h00;

  task automatic run_op(input bit wr, input logic [23:0] a, input logic [7:0] d, input bit poke);
    int oe_cnt = 0, we_cnt = 0, drv_cnt = 0, done_cnt = 0, done_idx = 0;
    int addr_bad = 0, data_bad = 0, clash = 0, busy_bad = 0, strobe_start = 0;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int idx = 1; idx <= 14; idx++) begin
      @(negedge clk);
      if (idx == 1) req_valid = 1'b0;
      if (poke && idx == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
      end
      if (poke && idx == 4) req_valid = 1'b0;
      if (!flash_ce_n && strobe_start == 0) strobe_start = idx;
      if (!flash_oe_n && !flash_ce_n && flash_we_n) oe_cnt++;
      if (!flash_we_n && !flash_ce_n && flash_oe_n) we_cnt++;
      if (flash_dq_oe == 8'hFF) begin
        drv_cnt++;
        if (flash_dq_out != d) data_bad++;
      end
      if ((!flash_oe_n && !flash_we_n) || (flash_dq_oe != 0 && !flash_oe_n)) clash++;
      if (done_cnt == 0 && flash_addr != a) addr_bad++;
      if (done_cnt == 0 && !done && busy != 1'b1) busy_bad++;
      if (done) begin
        if (done_cnt == 0) begin done_idx = idx; got = rd_data; end
        done_cnt++;
      end
    end
    if (wr) begin
      chk(we_cnt == WR, "R5 write strobe cycles", we_cnt, WR);
      chk(oe_cnt == 0, "R5 no oe during write", oe_cnt, 0);
      chk(drv_cnt == WR + 2, "R6 drive window", drv_cnt, WR + 2);
      chk(data_bad == 0, "R6 write data", data_bad, 0);
      chk(done_idx == WR + 3, "R8 write done cycle", done_idx, WR + 3);
      chk(got == last_rd, "R11 rd_data kept", got, last_rd);
      shadow[a[7:0]] = d;
    end else begin
      chk(oe_cnt == RD, "R3 read strobe cycles", oe_cnt, RD);
      chk(we_cnt == 0, "R3 no we during read", we_cnt, 0);
      chk(drv_cnt == 0, "R6 no drive on read", drv_cnt, 0);
      chk(done_idx == RD + 3, "R8 read done cycle", done_idx, RD + 3);
      chk(got == shadow[a[7:0]], "R4 read data", got, shadow[a[7:0]]);
      last_rd = shadow[a[7:0]];
    end
    chk(strobe_start == 2, "R3/R5 strobe start", strobe_start, 2);
    chk(addr_bad == 0, "R2 address stable", addr_bad, 0);
    chk(busy_bad == 0, "R8 busy window", busy_bad, 0);
    chk(done_cnt == 1, poke ? "R9 single done with mid-cycle request" : "R8 single done",
        done_cnt, 1);
    chk(clash == 0, "R10 strobe/drive exclusion", clash, 0);
    chk(flash_ce_n && flash_oe_n && flash_we_n && flash_dq_oe == 0 && !busy,
        "R1 idle after cycle", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    chk(rd_data == last_rd, "R4 rd_data held", rd_data, last_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    for (int i = 0; i < 256; i++) begin fmem[i] = 8'hFF; shadow[i] = 8'hFF; end
    seed_dummy = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(flash_ce_n && flash_oe_n && flash_we_n, "R1 strobes after reset",
        {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    chk(flash_dq_oe == 0 && !done && !busy, "R1 bus released after reset",
        {flash_dq_oe, done, busy}, 0);
    // Directed corners
    run_op(1'b0, 24'h000010, 8'h00, 1'b0);      // erased byte reads FF
    run_op(1'b1, 24'hFFFFFF, 8'h00, 1'b0);      // top of space
    run_op(1'b0, 24'hFFFFFF, 8'h00, 1'b0);
    run_op(1'b1, 24'h000000, 8'hA5, 1'b1);      // mid-cycle request ignored
    run_op(1'b0, 24'h000000, 8'h00, 1'b0);
    run_op(1'b0, 24'hFFFFFF, 8'h00, 1'b0);      // poke target not written (R9)
    run_op(1'b0, 24'h123456, 8'h00, 1'b1);
    run_op(1'b0, 24'hEDCBA9, 8'h00, 1'b0);      // R9 poke target still erased
    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [23:0] a;
      logic [7:0]  d;
      bit wr, pk;
      a  = {$urandom() % 24'hFFFF, 4'h0, 4'($urandom() % 16)};
      d  = 8'($urandom());
      wr = ($urandom() % 2) == 0;
      pk = ($urandom() % 5) == 0;
      if (pk) a[7:4] = 4'h0;
      if (pk && wr) shadow[8'(~a[7:0])] = shadow[8'(~a[7:0])];
      run_op(wr, a, d, pk);
    end
    for (int k = 0; k < 16; k++) run_op(1'b0, {20'h0, 4'(k)}, 8'h00, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule